// File: doc/BRIEF.md
# Wake-up and Power-Mode Sequencer

This block decides, cycle by cycle, how much of a contactless transceiver is powered. Two host pins select the resting condition: one is the main enable, the other keeps an auxiliary supply and a slow auxiliary clock alive while the rest of the chip sleeps. A power-up can also start on its own, with no host enable. This happens on a rising edge of the auxiliary pin, or when an antenna field level rises above a programmable threshold.

Such a self-started power-up is provisional. The block raises its internal enable and power request and waits for the oscillator to report stable. It then moves the clock select to the high-frequency clock and opens a confirmation window of a fixed number of clock cycles. If the host drives the main enable high inside that window, the power-up becomes permanent. If not, the block falls back to its resting state. For a field-started power-up, the arrival of the first received command also closes the window.

Interrupt flags record the field events and the receive-start events. Each flag holds until a host read strobe clears it.

Top module: `pwrseq_top`

## Requirements
- R1: With en_i and en2_i both low and no power-up in progress, int_en_o, pwr_req_o, aux_on_o and clk_sel_hf_o are all 0, and osc_ok_i has no effect on them.
- R2: At rest with en_i low and en2_i high, aux_on_o is 1 and int_en_o, pwr_req_o and clk_sel_hf_o are 0.
- R3: en_i high gives int_en_o = 1 and aux_on_o = 1 after one clock edge. While confirmed, clk_sel_hf_o equals osc_ok_i and pwr_req_o is 0. en_i has priority over any wake trigger.
- R4: A rising edge on en2_i at rest starts a provisional power-up. After the next edge, pwr_req_o and int_en_o are 1 and clk_sel_hf_o is 0 until osc_ok_i is seen high.
- R5: In a provisional power-up, osc_ok_i high sets clk_sel_hf_o one edge later and opens a window of WIN_CYC cycles. If en_i is still low in the last window cycle, the block returns to its resting state. The window count restarts on every attempt.
- R6: A det_thr_i of 0 disables field wake-up. With a nonzero threshold, field_lvl_i rising to a value strictly greater than det_thr_i starts a provisional power-up. A level equal to the threshold does not.
- R7: In a field-started power-up, the oscillator-stable event sets flag bit 2 (field change) of irq_flags_o, and irq_o goes high on the same edge that sets clk_sel_hf_o.
- R8: A rx_start_i pulse during a field-started power-up sets flag bit 6 (receive start). If en_i has not been confirmed, the same pulse ends the power-up. If en_i has been confirmed, it does not.
- R9: While a field-started power-up or confirmed target session is active, field_lvl_i falling to or below the threshold sets flag bit 2 again.
- R10: irq_rd_i clears all flags on the next edge. A flag set in the same cycle survives the clear. irq_o is the OR of the flags.
- R11: If en_i rises in the last cycle of the window, confirmation wins over expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-frequency clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Main host enable |
| en2_i | input | 1 | Auxiliary enable; rising edge wakes |
| osc_ok_i | input | 1 | Oscillator stable indication |
| field_lvl_i | input | LVL_W | Measured field level |
| det_thr_i | input | LVL_W | Field wake threshold; 0 disables |
| rx_start_i | input | 1 | First-command receive pulse |
| irq_rd_i | input | 1 | Host read strobe, clears flags |
| int_en_o | output | 1 | Internal enable |
| pwr_req_o | output | 1 | Provisional power-up request |
| aux_on_o | output | 1 | Auxiliary supply on |
| clk_sel_hf_o | output | 1 | 1 selects high-frequency clock, 0 the auxiliary clock |
| irq_o | output | 1 | Interrupt request |
| irq_flags_o | output | 8 | Flag register (bit 2 field change, bit 6 receive start) |

## Verification
Two pairs of events can fall in the same cycle. First, window expiry can coincide with host confirmation. The bench steps exactly to the last window cycle and raises en_i there, and expects a confirmed session with pwr_req_o low rather than a fallback. Second, a new field-change event can coincide with a host read strobe. The bench drops the field during a confirmed target session while it pulses irq_rd_i, and expects bit 2 to stay set while the older bit 6 is cleared.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_SLEEP,
    ST_WAIT_OSC,
    ST_WINDOW,
    ST_ON
  } pwr_state_e;

  localparam int FLAG_W      = 8;
  localparam int FLG_FIELD   = 2;
  localparam int FLG_RXSTART = 6;
endpackage

// File: rtl/pwrseq_trig.sv
module pwrseq_trig #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en2_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             en2_rise_o,
  output logic             hit_rise_o,
  output logic             hit_fall_o
);
  logic en2_q, hit_q, hit;

  // threshold 0 disables field detection
  assign hit = (thr_i != '0) && (lvl_i > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en2_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      en2_q <= en2_i;
      hit_q <= hit;
    end
  end

  assign en2_rise_o = en2_i & ~en2_q;
  assign hit_rise_o = hit & ~hit_q;
  assign hit_fall_o = ~hit & hit_q;
endmodule

// File: rtl/pwrseq_win.sv
module pwrseq_win #(
  parameter int WIN_CYC = 1356
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_irq.sv
module pwrseq_irq #(
  parameter int FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              clr_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
    logic f_q;
    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[b]) f_q <= 1'b1;
      else if (clr_i)    f_q <= 1'b0;
    end
    assign flags_o[b] = f_q;
  end

  assign irq_o = |flags_o;
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int WIN_CYC = 1356
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              en2_i,
  input  logic              osc_ok_i,
  input  logic [LVL_W-1:0]  field_lvl_i,
  input  logic [LVL_W-1:0]  det_thr_i,
  input  logic              rx_start_i,
  input  logic              irq_rd_i,
  output logic              int_en_o,
  output logic              pwr_req_o,
  output logic              aux_on_o,
  output logic              clk_sel_hf_o,
  output logic              irq_o,
  output logic [FLAG_W-1:0] irq_flags_o
);
  pwr_state_e st_q, st_d;
  logic tgt_q, tgt_d;
  logic en2_rise, hit_rise, hit_fall, win_last;
  logic [FLAG_W-1:0] flag_set;
  pwr_state_e rest_st;
  logic at_rest, powered;

  pwrseq_trig #(.LVL_W(LVL_W)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en2_i      (en2_i),
    .lvl_i      (field_lvl_i),
    .thr_i      (det_thr_i),
    .en2_rise_o (en2_rise),
    .hit_rise_o (hit_rise),
    .hit_fall_o (hit_fall)
  );

  pwrseq_win #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_WINDOW),
    .last_o (win_last)
  );

  assign rest_st = en2_i ? ST_SLEEP : ST_OFF;
  assign at_rest = (st_q == ST_OFF) || (st_q == ST_SLEEP);
  assign powered = (st_q == ST_WAIT_OSC) || (st_q == ST_WINDOW) || (st_q == ST_ON);

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    unique case (st_q)
      ST_OFF, ST_SLEEP: begin
        if (en_i) begin
          st_d  = ST_ON;
          tgt_d = 1'b0;
        end else if (en2_rise || hit_rise) begin
          st_d  = ST_WAIT_OSC;
          tgt_d = hit_rise;
        end else begin
          st_d = rest_st;
        end
      end
      ST_WAIT_OSC: if (osc_ok_i) st_d = en_i ? ST_ON : ST_WINDOW;
      ST_WINDOW: begin
        if (en_i)                                 st_d = ST_ON;
        else if (win_last || (tgt_q && rx_start_i)) st_d = rest_st;
      end
      ST_ON: if (!en_i) st_d = rest_st;
      default: st_d = ST_OFF;
    endcase
    if (st_d == ST_OFF || st_d == ST_SLEEP) tgt_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      tgt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    flag_set = '0;
    flag_set[FLG_FIELD] = tgt_q && (((st_q == ST_WAIT_OSC) && osc_ok_i) ||
                                    (powered && hit_fall));
    flag_set[FLG_RXSTART] = tgt_q && rx_start_i &&
                            ((st_q == ST_WINDOW) || (st_q == ST_ON));
  end

  pwrseq_irq #(.FLAG_W(FLAG_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (irq_rd_i),
    .flags_o (irq_flags_o),
    .irq_o   (irq_o)
  );

  assign int_en_o     = powered;
  assign pwr_req_o    = (st_q == ST_WAIT_OSC) || (st_q == ST_WINDOW);
  assign aux_on_o     = !(st_q == ST_OFF);
  assign clk_sel_hf_o = (st_q == ST_WINDOW) || ((st_q == ST_ON) && osc_ok_i);

  logic unused_rest;
  assign unused_rest = at_rest;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int LVL_W   = 3,
  parameter int WIN_CYC = 1356
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             en2_i,
  input logic [LVL_W-1:0] det_thr_i,
  input logic             irq_rd_i,
  input logic             int_en_o,
  input logic             pwr_req_o,
  input logic             aux_on_o,
  input logic             clk_sel_hf_o,
  input logic [7:0]       irq_flags_o
);
  localparam int HW = $clog2(WIN_CYC + 2);
  logic [HW-1:0] hf_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hf_cnt <= '0;
    else if (pwr_req_o && clk_sel_hf_o) hf_cnt <= hf_cnt + 1'b1;
    else                                hf_cnt <= '0;
  end

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_cnt <= HW'(WIN_CYC)); // R5

  AST_HF_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_hf_o |-> (int_en_o && aux_on_o)); // R3

  AST_EN2_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_o && !en_i && en2_i && !$past(en2_i)) |=> pwr_req_o); // R4

  AST_OFF_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_thr_i == '0 && !en_i && !en2_i && !int_en_o)
      |=> (!int_en_o && !aux_on_o && !clk_sel_hf_o)); // R6

  AST_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_req_o && clk_sel_hf_o && en_i) |=> (int_en_o && !pwr_req_o)); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(irq_rd_i) |-> (($past(irq_flags_o) & ~irq_flags_o) == 8'h00)); // R10
endmodule

bind pwrseq_top pwrseq_chk #(.LVL_W(LVL_W), .WIN_CYC(WIN_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .en2_i        (en2_i),
  .det_thr_i    (det_thr_i),
  .irq_rd_i     (irq_rd_i),
  .int_en_o     (int_en_o),
  .pwr_req_o    (pwr_req_o),
  .aux_on_o     (aux_on_o),
  .clk_sel_hf_o (clk_sel_hf_o),
  .irq_flags_o  (irq_flags_o)
);

// File: tb/pwrseq_top_test.sv
module pwrseq_top_test;
  localparam int WIN = 1356;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, en2 = 0, osc = 0, rx = 0, rd = 0;
  logic [2:0] lvl = 3'd7, thr = 3'd0;
  logic int_en, pwr_req, aux_on, hf, irq;
  logic [7:0] flags;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  pwrseq_top #(.LVL_W(3), .WIN_CYC(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .en2_i(en2), .osc_ok_i(osc),
    .field_lvl_i(lvl), .det_thr_i(thr), .rx_start_i(rx), .irq_rd_i(rd),
    .int_en_o(int_en), .pwr_req_o(pwr_req), .aux_on_o(aux_on),
    .clk_sel_hf_o(hf), .irq_o(irq), .irq_flags_o(flags)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [3:0] exp);
    chk(req, {4'h0, int_en, pwr_req, aux_on, hf}, {4'h0, exp});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {en, en2, osc, int_en, pwr_req, aux_on, hf}
  localparam logic [6:0] VEC [8] = '{
    7'b000_0000,  // R1
    7'b100_1010,  // R3
    7'b101_1011,  // R3
    7'b011_0010,  // R2
    7'b010_0010,  // R2
    7'b000_0000,  // R1
    7'b110_1010,  // R3 priority over en2 edge
    7'b001_0000   // R1 osc ignored
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    outs("R1 reset", 4'b0000);
    chk("R10 reset flags", flags, 8'h00);

    // table: threshold 0 with high level exercises R6 disable
    for (int i = 0; i < 8; i++) begin
      {en, en2, osc} = VEC[i][6:4];
      step();
      outs(i < 6 ? "R1/R2/R3 table" : "R3/R1 table", VEC[i][3:0]);
      chk("R6 no field wake", {7'h0, irq}, 8'h00);
    end

    // R4 / R5 window expiry
    osc = 0; en = 0; en2 = 0; step();
    en2 = 1; step();
    outs("R4 en2 rise", 4'b1110);
    osc = 1; step();
    outs("R5 hf after osc", 4'b1111);
    repeat (WIN - 1) step();
    outs("R5 last window cycle", 4'b1111);
    step();
    outs("R5 expiry to sleep R2", 4'b0010);
    chk("R5 no flags pin start", flags, 8'h00);

    // R11 confirm in last cycle, window restarted
    en2 = 0; step();
    outs("R1 back off", 4'b0000);
    en2 = 1; step();
    step();
    outs("R5 new window", 4'b1111);
    repeat (WIN - 1) step();
    en = 1; step();
    outs("R11 confirm wins", 4'b1011);
    en = 0; en2 = 0; step();
    outs("R1 off after session", 4'b0000);

    // R6 / R7 / R8 / R10 field wake unconfirmed
    osc = 0; thr = 3'd3; lvl = 3'd3; step();
    outs("R6 equal level no wake", 4'b0000);
    lvl = 3'd4; step();
    outs("R6 field wake", 4'b1110);
    chk("R7 no flag before osc", flags, 8'h00);
    osc = 1; step();
    chk("R7 field flag", flags, 8'h04);
    chk("R7 irq", {7'h0, irq}, 8'h01);
    outs("R5 field window", 4'b1111);
    rx = 1; step(); rx = 0;
    chk("R8 rx flag", flags, 8'h44);
    outs("R8 abort", 4'b0000);
    rd = 1; step(); rd = 0;
    chk("R10 clear", flags, 8'h00);
    chk("R10 irq low", {7'h0, irq}, 8'h00);
    lvl = 3'd0; step();

    // R8 / R9 / R10 confirmed target
    lvl = 3'd5; step();
    outs("R6 wake again", 4'b1110);
    step();
    chk("R7 field flag again", flags, 8'h04);
    en = 1; step();
    outs("R3 confirmed target", 4'b1011);
    rd = 1; step(); rd = 0;
    chk("R10 clear in session", flags, 8'h00);
    rx = 1; step(); rx = 0;
    chk("R8 rx flag confirmed", flags, 8'h40);
    outs("R8 no abort confirmed", 4'b1011);
    lvl = 3'd0; rd = 1; step(); rd = 0;
    chk("R9 field drop with R10 set wins", flags, 8'h04);
    en = 0; step();
    outs("R1 end", 4'b0000);
    rd = 1; step(); rd = 0;
    chk("R10 final clear", flags, 8'h00);

    finish_run();
  end
endmodule